// File: doc/BRIEF.md
# TLB Control and Replacement-Way Register

This block is the control register that sits beside a 4-way set-associative TLB. Software reads and writes one 32-bit word that enables address translation, picks how the TLB set index is formed and selects single or multiple virtual-memory operation. Writing a one to the flush field does not store anything. Instead, the block emits a one-cycle pulse that the valid-bit array uses to clear every entry.

The block also keeps a 2-bit replacement counter. Hardware updates it whenever the MMU raises an exception, and the current value is driven out as the way that a refill should write. On a miss, an empty way in the indexed set is preferred, searching from way 0 upward. When the set is full, the counter advances by one. Any other MMU exception loads the number of the way that caused the fault. The TLB set index is built from the page-number bits of the faulting address. Depending on the index mode, it is used either directly or XORed with the low bits of the address-space identifier.

Top module: `mmu_ctl_top`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0, `repl_way` is 0 and `flush_pulse` is 0.
- R2: A write stores bit 0 (translation enable), bit 1 (index mode), bits 5:4 (replacement counter) and bit 8 (single-virtual-memory mode). All other bits always read as 0, whatever was written to them.
- R3: A write with bit 2 set drives `flush_pulse` high for exactly the one cycle after the write edge. Bit 2 always reads as 0.
- R4: With index mode 0, `set_index` equals `vpn_bits`, which carries address bits 16:12.
- R5: With index mode 1, `set_index` equals `vpn_bits` XOR `asid_lo`, where `asid_lo` carries ASID bits 4:0.
- R6: On `tlb_miss` with all four bits of `set_valid` set, the counter advances by 1 modulo 4.
- R7: On `tlb_miss` with at least one `set_valid` bit clear, the counter loads the lowest-numbered clear way. `set_valid[n]` belongs to way n.
- R8: On `mmu_exc` without `tlb_miss`, the counter loads `exc_way`.
- R9: If a hardware update and a register write fall in the same cycle, the counter takes the hardware value. The write's other fields still take effect.
- R10: If `tlb_miss` and `mmu_exc` are both high, the miss rule is applied and `exc_way` is ignored.
- R11: `repl_way` always equals the counter field read at bits 5:4 of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read word |
| tlb_miss | input | 1 | TLB miss event, one-cycle pulse |
| mmu_exc | input | 1 | Other MMU exception event, one-cycle pulse |
| exc_way | input | 2 | Way that caused the other exception |
| set_valid | input | 4 | Valid bits of the four ways in the indexed set |
| vpn_bits | input | 5 | Virtual page number bits 16:12 |
| asid_lo | input | 5 | ASID bits 4:0 |
| set_index | output | 5 | TLB set index |
| flush_pulse | output | 1 | One-cycle clear of all TLB valid bits |
| repl_way | output | 2 | Way selected for the next refill |

## Verification
The miss rule is exercised with several set-valid patterns. A full set starting from counter value 3 shows the wrap to 0. Patterns whose lowest clear way is 0, 1, 2 or 3 show that the search favours the low end and is not a plain increment. A faulting-way exception issued after a miss shows that a fault loads `exc_way` rather than advancing the counter. Combined cycles cover the two collisions: a miss against a counter write, where the other fields must still change, and a miss together with an exception. Finally, the set index is sampled in both index modes using an ASID pattern that makes the two results differ.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int IDX_W    = 5;

    localparam int POS_XLATE = 0;
    localparam int POS_HASH  = 1;
    localparam int POS_FLUSH = 2;
    localparam int POS_CTR   = 4;
    localparam int POS_SVM   = 8;

    typedef struct packed {
        logic             svm;
        logic [WAY_W-1:0] ctr;
        logic             hash;
        logic             xlate;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_MISS  = 2'd1,
        EV_FAULT = 2'd2
    } mmu_evt_t;

    function automatic logic [REG_W-1:0] pack_ctl(input ctl_fields_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_XLATE] = f.xlate;
        w[POS_HASH]  = f.hash;
        w[POS_CTR +: WAY_W] = f.ctr;
        w[POS_SVM]   = f.svm;
        return w;
    endfunction

    function automatic ctl_fields_t unpack_ctl(input logic [REG_W-1:0] w);
        ctl_fields_t f;
        f.xlate = w[POS_XLATE];
        f.hash  = w[POS_HASH];
        f.ctr   = w[POS_CTR +: WAY_W];
        f.svm   = w[POS_SVM];
        return f;
    endfunction

    function automatic mmu_evt_t classify(input logic miss, input logic fault);
        if (miss)
            return EV_MISS;
        else if (fault)
            return EV_FAULT;
        return EV_NONE;
    endfunction
endpackage

// File: rtl/mmu_ctl_fields.sv
module mmu_ctl_fields
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              xlate,
    output logic              hash,
    output logic              svm,
    output logic              flush_pulse
);
    ctl_fields_t wr_f;

    always_comb wr_f = unpack_ctl(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            xlate       <= 1'b0;
            hash        <= 1'b0;
            svm         <= 1'b0;
            flush_pulse <= 1'b0;
        end else begin
            flush_pulse <= wr_en & wr_data[POS_FLUSH];
            if (wr_en) begin
                xlate <= wr_f.xlate;
                hash  <= wr_f.hash;
                svm   <= wr_f.svm;
            end
        end
    end
endmodule

// File: rtl/mmu_repl_ctr.sv
module mmu_repl_ctr
    import mmu_ctl_pkg::*;
#(
    parameter int WAYS = NUM_WAYS,
    localparam int WW  = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we,
    input  logic [WW-1:0]   sw_val,
    input  logic            miss,
    input  logic            fault,
    input  logic [WW-1:0]   fault_way,
    input  logic [WAYS-1:0] set_valid,
    output logic [WW-1:0]   ctr
);
    mmu_evt_t        evt;
    logic [WW-1:0]   first_free;
    logic            set_full;
    logic [WAYS-1:0] hit_free;
    logic [WW-1:0]   ctr_nxt;

    // one-hot of the lowest clear valid bit
    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_free
            if (g == 0) begin : g_first
                assign hit_free[g] = ~set_valid[g];
            end else begin : g_rest
                assign hit_free[g] = ~set_valid[g] & (&set_valid[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        first_free = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_free[w]) first_free = WW'(w);
    end

    assign set_full = &set_valid;
    assign evt      = classify(miss, fault);

    always_comb begin
        unique case (evt)
            EV_MISS:  ctr_nxt = set_full ? ctr + WW'(1) : first_free;
            EV_FAULT: ctr_nxt = fault_way;
            default:  ctr_nxt = sw_we ? sw_val : ctr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctr <= '0;
        else     ctr <= ctr_nxt;
    end
endmodule

// File: rtl/mmu_set_index.sv
module mmu_set_index #(
    parameter int IW = 5
) (
    input  logic          hash_en,
    input  logic [IW-1:0] vpn_bits,
    input  logic [IW-1:0] asid_lo,
    output logic [IW-1:0] set_index
);
    genvar i;
    generate
        for (i = 0; i < IW; i++) begin : g_bit
            assign set_index[i] = vpn_bits[i] ^ (hash_en & asid_lo[i]);
        end
    endgenerate
endmodule

// File: rtl/mmu_ctl_top.sv
module mmu_ctl_top
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int WAYS   = NUM_WAYS,
    parameter int IW     = IDX_W,
    localparam int WW    = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tlb_miss,
    input  logic              mmu_exc,
    input  logic [WW-1:0]     exc_way,
    input  logic [WAYS-1:0]   set_valid,
    input  logic [IW-1:0]     vpn_bits,
    input  logic [IW-1:0]     asid_lo,
    output logic [IW-1:0]     set_index,
    output logic              flush_pulse,
    output logic [WW-1:0]     repl_way
);
    ctl_fields_t cur;
    logic        xlate, hash, svm;
    logic [WW-1:0] ctr;

    mmu_ctl_fields #(.DATA_W(DATA_W)) u_fields (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .xlate(xlate), .hash(hash), .svm(svm), .flush_pulse(flush_pulse)
    );

    mmu_repl_ctr #(.WAYS(WAYS)) u_ctr (
        .clk(clk), .rst(rst), .sw_we(wr_en),
        .sw_val(wr_data[POS_CTR +: WW]),
        .miss(tlb_miss), .fault(mmu_exc), .fault_way(exc_way),
        .set_valid(set_valid), .ctr(ctr)
    );

    mmu_set_index #(.IW(IW)) u_idx (
        .hash_en(hash), .vpn_bits(vpn_bits), .asid_lo(asid_lo),
        .set_index(set_index)
    );

    always_comb begin
        cur.xlate = xlate;
        cur.hash  = hash;
        cur.svm   = svm;
        cur.ctr   = ctr;
    end

    assign rd_data  = pack_ctl(cur);
    assign repl_way = ctr;
endmodule

// File: rtl/mmu_ctl_checker.sv
module mmu_ctl_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        tlb_miss,
    input logic        mmu_exc,
    input logic [1:0]  exc_way,
    input logic [3:0]  set_valid,
    input logic [4:0]  vpn_bits,
    input logic [4:0]  asid_lo,
    input logic [4:0]  set_index,
    input logic        flush_pulse,
    input logic [1:0]  repl_way
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~32'h0000_0133) == 32'h0);

    p_flush_cause_r3: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> $past(wr_en && wr_data[2]));

    p_plain_index_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_data[1] |-> set_index == vpn_bits);

    p_hashed_index_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data[1] |-> set_index == (vpn_bits ^ asid_lo));

    p_full_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (tlb_miss && set_valid == 4'hF) |=> repl_way == $past(repl_way) + 2'd1);

    p_way0_free_r7: assert property (@(posedge clk) disable iff (rst)
        (tlb_miss && !set_valid[0]) |=> repl_way == 2'd0);

    p_way1_free_r7: assert property (@(posedge clk) disable iff (rst)
        (tlb_miss && set_valid[0] && !set_valid[1]) |=> repl_way == 2'd1);

    p_fault_load_r8: assert property (@(posedge clk) disable iff (rst)
        (mmu_exc && !tlb_miss) |=> repl_way == $past(exc_way));

    p_other_fields_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (tlb_miss || mmu_exc)) |=> rd_data[8] == $past(wr_data[8]));

    p_way_matches_r11: assert property (@(posedge clk) disable iff (rst)
        repl_way == rd_data[5:4]);
endmodule

bind mmu_ctl_top mmu_ctl_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tlb_miss(tlb_miss), .mmu_exc(mmu_exc), .exc_way(exc_way),
    .set_valid(set_valid), .vpn_bits(vpn_bits), .asid_lo(asid_lo),
    .set_index(set_index), .flush_pulse(flush_pulse), .repl_way(repl_way)
);

// File: tb/mmu_ctl_top_test.sv
`timescale 1ns/1ps
module mmu_ctl_top_test;
    typedef struct {
        string       req;
        logic [31:0] rd;
        logic [1:0]  way;
        logic        flush;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tlb_miss = 1'b0, mmu_exc = 1'b0;
    logic [1:0]  exc_way = '0;
    logic [3:0]  set_valid = '0;
    logic [4:0]  vpn_bits = '0, asid_lo = '0;
    logic [4:0]  set_index;
    logic        flush_pulse;
    logic [1:0]  repl_way;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    exp_t q[$];

    // bench model of the register fields
    logic m_at = 0, m_ix = 0, m_sv = 0;
    logic [1:0] m_rc = 0;

    always #10 clk = ~clk;

    mmu_ctl_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tlb_miss(tlb_miss), .mmu_exc(mmu_exc), .exc_way(exc_way),
        .set_valid(set_valid), .vpn_bits(vpn_bits), .asid_lo(asid_lo),
        .set_index(set_index), .flush_pulse(flush_pulse), .repl_way(repl_way)
    );

    function automatic logic [31:0] model_word();
        return {23'b0, m_sv, 2'b0, m_rc, 2'b0, m_ix, m_at};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expectations one cycle after each driven step
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " rd_data"}, rd_data, e.rd);
                check({e.req, " repl_way"}, {30'b0, repl_way}, {30'b0, e.way});
                check({e.req, " flush_pulse"}, {31'b0, flush_pulse}, {31'b0, e.flush});
                check("R11 way equals field", {30'b0, repl_way}, {30'b0, rd_data[5:4]});
            end
        end
    end

    task automatic step(input string req, input logic we, input logic [31:0] wd,
                        input logic miss, input logic exc, input logic [1:0] ew,
                        input logic [3:0] valid);
        exp_t e;
        logic [1:0] nrc;
        @(negedge clk);
        wr_en = we; wr_data = wd; tlb_miss = miss; mmu_exc = exc;
        exc_way = ew; set_valid = valid;
        nrc = m_rc;
        if (we) begin
            m_at = wd[0]; m_ix = wd[1]; m_sv = wd[8]; nrc = wd[5:4];
        end
        if (miss) begin
            if (valid == 4'hF)      nrc = m_rc + 2'd1;
            else if (!valid[0])     nrc = 2'd0;
            else if (!valid[1])     nrc = 2'd1;
            else if (!valid[2])     nrc = 2'd2;
            else                    nrc = 2'd3;
        end else if (exc) begin
            nrc = ew;
        end
        m_rc = nrc;
        @(posedge clk);
        e.req = req; e.rd = model_word(); e.way = m_rc; e.flush = we & wd[2];
        q.push_back(e);
        #1;
        wr_en = 0; tlb_miss = 0; mmu_exc = 0;
    endtask

    task automatic idx_check(input string req, input logic [4:0] v, input logic [4:0] a);
        @(negedge clk);
        vpn_bits = v; asid_lo = a;
        #1;
        check(req, {27'b0, set_index}, {27'b0, (m_ix ? (v ^ a) : v)});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        @(negedge clk);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 repl_way", {30'b0, repl_way}, 32'h0);
        check("R1 flush_pulse", {31'b0, flush_pulse}, 32'h0);

        // R2 reserved bits read 0, R3 flush pulse and bit 2 reads 0
        step("R2 R3 all-ones write", 1, 32'hFFFF_FFFF, 0, 0, 2'd0, 4'hF);
        step("R3 pulse ends", 0, 32'h0, 0, 0, 2'd0, 4'hF);
        step("R2 field write", 1, 32'h0000_0121, 0, 0, 2'd0, 4'hF);

        // R4 plain index, R5 hashed index
        idx_check("R4 plain index", 5'h16, 5'h0B);
        step("R5 set hash mode", 1, 32'h0000_0033, 0, 0, 2'd0, 4'hF);
        idx_check("R5 hashed index", 5'h16, 5'h0B);
        idx_check("R5 hashed index b", 5'h1F, 5'h1F);

        // R6 full set advances and wraps from 3
        step("R6 wrap 3->0", 0, 32'h0, 1, 0, 2'd0, 4'hF);
        step("R6 advance 0->1", 0, 32'h0, 1, 0, 2'd0, 4'hF);

        // R7 lowest clear way
        step("R7 free way0", 0, 32'h0, 1, 0, 2'd0, 4'b1010);
        step("R7 free way1", 0, 32'h0, 1, 0, 2'd0, 4'b1101);
        step("R7 free way3", 0, 32'h0, 1, 0, 2'd0, 4'b0111);
        step("R7 free way2", 0, 32'h0, 1, 0, 2'd0, 4'b1011);

        // R8 faulting way loaded
        step("R8 fault way1", 0, 32'h0, 0, 1, 2'd1, 4'hF);
        step("R8 fault way3", 0, 32'h0, 0, 1, 2'd3, 4'hF);

        // R9 hardware wins over write of counter, other fields still written
        step("R9 write vs miss", 1, 32'h0000_0110, 1, 0, 2'd0, 4'hF);
        step("R9 write vs fault", 1, 32'h0000_0031, 0, 1, 2'd2, 4'hF);

        // R10 miss beats concurrent exception
        step("R10 miss over exc", 0, 32'h0, 1, 1, 2'd1, 4'b0111);
        step("R10 full miss over exc", 0, 32'h0, 1, 1, 2'd0, 4'hF);

        // R2 direct counter write with no event
        step("R2 counter write", 1, 32'h0000_0020, 0, 0, 2'd0, 4'hF);
        idx_check("R4 plain after clear", 5'h09, 5'h1F);
        step("idle", 0, 32'h0, 0, 0, 2'd0, 4'hF);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule